// File: doc/BRIEF.md
# Dual-Channel Converter Serial Load Front End

This block is the digital front end of a two-channel digital-to-analog converter. A host shifts a 24-bit command word in over a serial line. The shift register steps on every rising edge of the logical OR of chip-select and serial clock. A level-sensitive load strobe copies the 16-bit data field into one or both input registers. A separate transfer strobe then copies both input registers into the output registers on the same edge. The host can therefore stage new codes for both channels and change the analog outputs together.

A level-sensitive clear pin forces every input and output register to zero-scale or to mid-scale, as a select pin chooses. The clear pin does not touch the shift register. The most significant bit of the shift register drives a serial output, so several devices can be chained with each device's serial output feeding the next device's serial input. All pins are brought into the system clock domain through synchronizer flops. Edges are found by comparing successive synchronized samples. The two output register values are presented as parallel buses.

Top module: `dual_dac_loader`

## Requirements
- R1: On every rising edge of (csel_n_i OR sclk_i), the 24-bit shift register moves one place toward its MSB and takes sdin_i as its new LSB. sdout_o always shows the MSB (bit 23). A power-on reset (por_n_i low) clears the shift register and all data registers to zero.
- R2: While load_n_i is low and clr_n_i is high, a word with bit 23 = 0 and bit 21 = 0 makes input register A follow bits 15..0 of the shift register. Input register B keeps its value.
- R3: While load_n_i is low and clr_n_i is high, a word with bit 23 = 1 and bit 21 = 0 makes input register B follow bits 15..0. Input register A keeps its value.
- R4: When bit 21 is 1, a load writes bits 15..0 into both input registers, whatever bit 23 holds. Bit 22 and bits 20..16 have no effect on any register.
- R5: While load_n_i is high, both input registers hold, even when new words are shifted in.
- R6: Output registers ch_a_o and ch_b_o copy input registers A and B together on a low-to-high transition of xfer_i. At all other times they hold, and that includes while xfer_i stays high.
- R7: While clr_n_i is low, all four data registers are forced to 16'h0000 when clr_mid_i is low and to 16'h8000 when clr_mid_i is high. A clear overrides both load and transfer.
- R8: Asserting and then releasing clr_n_i leaves the shift register contents unchanged.
- R9: If csel_n_i rises while sclk_i is low, the OR of the two produces a rising edge. The register then shifts one extra bit.
- R10: When three devices are chained serial output to serial input and share all other pins, a stream of 72 bits leaves each device holding its own 24-bit word. The word shifted in first ends up in the device furthest from the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Asynchronous power-on reset, active low |
| csel_n_i | input | 1 | Chip select, ORed with the serial clock to form the shift clock |
| sclk_i | input | 1 | Serial clock |
| sdin_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Level load strobe, active low |
| xfer_i | input | 1 | Output transfer strobe, acts on its rising edge |
| clr_n_i | input | 1 | Clear, active low, level-sensitive |
| clr_mid_i | input | 1 | Clear value select: 0 gives zero-scale, 1 gives mid-scale |
| sdout_o | output | 1 | Serial data out, the shift register MSB |
| ch_a_o | output | 16 | Output register of channel A |
| ch_b_o | output | 16 | Output register of channel B |

## Verification
The chip-select rise and the serial clock rise can merge into a single shift edge. When the clock is already low, a chip-select rise adds one more shift. The bench provokes this by dropping the serial clock before it releases chip-select. It checks the result through a later load and transfer, and also through the serial output, against a bench model that shifts on every rising edge of the OR of the two pins it drives. Clear and transfer can also fall in the same window. The bench holds clear low while it pulses transfer and expects the clear value to win.

// File: rtl/ddl_pkg.sv
package ddl_pkg;
   localparam int unsigned DEF_FRAME_W   = 24;
   localparam int unsigned DEF_VAL_W     = 16;
   localparam int unsigned DEF_CHSEL_POS = 23;
   localparam int unsigned DEF_QUICK_POS = 21;
   localparam int unsigned DEF_SYNC      = 2;

   // index of each pin in the synchronizer bank
   localparam int unsigned PIN_CSEL  = 0;
   localparam int unsigned PIN_SCLK  = 1;
   localparam int unsigned PIN_SDIN  = 2;
   localparam int unsigned PIN_LOAD  = 3;
   localparam int unsigned PIN_XFER  = 4;
   localparam int unsigned PIN_CLR   = 5;
   localparam int unsigned PIN_MID   = 6;
   localparam int unsigned PIN_COUNT = 7;

   // idle levels so that power-on release creates no false edge or strobe
   localparam logic [PIN_COUNT-1:0] PIN_IDLE = 7'b0101011;
endpackage

// File: rtl/ddl_sync.sv
module ddl_sync #(
   parameter int unsigned              N       = 1,
   parameter int unsigned              STAGES  = 2,
   parameter logic [N-1:0]             RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("ddl_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] ff;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ff <= {STAGES{RST_VAL[i]}};
         else        ff <= {ff[STAGES-2:0], d[i]};
      end
      assign q[i] = ff[STAGES-1];
   end
endmodule

// File: rtl/ddl_shifter.sv
module ddl_shifter #(
   parameter int unsigned W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_s,
   input  logic         din_s,
   output logic         step,
   output logic [W-1:0] sr
);
   logic sclk_prev;

   assign step = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b1;
         sr        <= '0;
      end else begin
         sclk_prev <= sclk_s;
         if (step) sr <= {sr[W-2:0], din_s};
      end
   end
endmodule

// File: rtl/ddl_channel.sv
module ddl_channel #(
   parameter int unsigned VAL_W = 16,
   parameter int unsigned CH_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_act,
   input  logic [VAL_W-1:0] clr_val,
   input  logic             load_act,
   input  logic             sel_bit,
   input  logic             quick,
   input  logic [VAL_W-1:0] data,
   input  logic             xfer_rise,
   output logic [VAL_W-1:0] in_q,
   output logic [VAL_W-1:0] out_q
);
   localparam logic MY_SEL = (CH_ID % 2) == 1;

   logic hit;
   assign hit = quick | (sel_bit == MY_SEL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  in_q <= '0;
      else if (clr_act)            in_q <= clr_val;
      else if (load_act && hit)    in_q <= data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  out_q <= '0;
      else if (clr_act)            out_q <= clr_val;
      else if (xfer_rise)          out_q <= in_q;
   end
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
   import ddl_pkg::*;
#(
   parameter int unsigned FRAME_W     = DEF_FRAME_W,
   parameter int unsigned VAL_W       = DEF_VAL_W,
   parameter int unsigned CHSEL_POS   = DEF_CHSEL_POS,
   parameter int unsigned QUICK_POS   = DEF_QUICK_POS,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic             clk_i,
   input  logic             por_n_i,
   input  logic             csel_n_i,
   input  logic             sclk_i,
   input  logic             sdin_i,
   input  logic             load_n_i,
   input  logic             xfer_i,
   input  logic             clr_n_i,
   input  logic             clr_mid_i,
   output logic             sdout_o,
   output logic [VAL_W-1:0] ch_a_o,
   output logic [VAL_W-1:0] ch_b_o
);
   localparam int unsigned      N_CH     = 2;
   localparam logic [VAL_W-1:0] MID_VAL  = {1'b1, {(VAL_W-1){1'b0}}};
   localparam logic [VAL_W-1:0] ZERO_VAL = '0;

   if (CHSEL_POS >= FRAME_W || QUICK_POS >= FRAME_W) begin : g_bad_pos
      $error("dual_dac_loader: control bit outside the frame");
   end
   if (VAL_W > QUICK_POS || VAL_W > CHSEL_POS || QUICK_POS == CHSEL_POS) begin : g_bad_overlap
      $error("dual_dac_loader: data field overlaps control bits");
   end

   logic [PIN_COUNT-1:0] pins_raw, pins_s;
   assign pins_raw = {clr_mid_i, clr_n_i, xfer_i, load_n_i, sdin_i, sclk_i, csel_n_i};

   ddl_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk_i), .rst_n(por_n_i), .d(pins_raw), .q(pins_s)
   );

   logic csel_s, sclk_s, sdin_s, load_n_s, xfer_s, clr_n_s, clr_mid_s;
   assign csel_s    = pins_s[PIN_CSEL];
   assign sclk_s    = pins_s[PIN_SCLK];
   assign sdin_s    = pins_s[PIN_SDIN];
   assign load_n_s  = pins_s[PIN_LOAD];
   assign xfer_s    = pins_s[PIN_XFER];
   assign clr_n_s   = pins_s[PIN_CLR];
   assign clr_mid_s = pins_s[PIN_MID];

   logic               shift_step;
   logic [FRAME_W-1:0] shreg;

   ddl_shifter #(.W(FRAME_W)) u_shift (
      .clk(clk_i), .rst_n(por_n_i), .sclk_s(csel_s | sclk_s), .din_s(sdin_s),
      .step(shift_step), .sr(shreg)
   );
   assign sdout_o = shreg[FRAME_W-1];

   logic xfer_prev, xfer_rise;
   always_ff @(posedge clk_i or negedge por_n_i) begin
      if (!por_n_i) xfer_prev <= 1'b0;
      else          xfer_prev <= xfer_s;
   end
   assign xfer_rise = xfer_s & ~xfer_prev;

   logic [VAL_W-1:0] clr_val;
   assign clr_val = clr_mid_s ? MID_VAL : ZERO_VAL;

   logic [VAL_W-1:0] in_q  [N_CH];
   logic [VAL_W-1:0] out_q [N_CH];

   for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
      ddl_channel #(.VAL_W(VAL_W), .CH_ID(ch)) u_ch (
         .clk(clk_i), .rst_n(por_n_i),
         .clr_act(~clr_n_s), .clr_val(clr_val),
         .load_act(~load_n_s),
         .sel_bit(shreg[CHSEL_POS]), .quick(shreg[QUICK_POS]),
         .data(shreg[VAL_W-1:0]), .xfer_rise(xfer_rise),
         .in_q(in_q[ch]), .out_q(out_q[ch])
      );
   end

   logic [VAL_W-1:0] in_a, in_b;
   assign in_a   = in_q[0];
   assign in_b   = in_q[1];
   assign ch_a_o = out_q[0];
   assign ch_b_o = out_q[1];
endmodule

// File: rtl/ddl_checker.sv
module ddl_checker #(
   parameter int unsigned W = 24,
   parameter int unsigned V = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         step,
   input logic         din,
   input logic [W-1:0] sr,
   input logic         xfer_rise,
   input logic         clr_n,
   input logic         clr_mid,
   input logic         load_n,
   input logic [V-1:0] in_a,
   input logic [V-1:0] in_b,
   input logic [V-1:0] out_a,
   input logic [V-1:0] out_b
);
   localparam logic [V-1:0] MID = {1'b1, {(V-1){1'b0}}};

   assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> sr == {$past(sr[W-2:0]), $past(din)});

   // R8: without a shift edge nothing (clear included) moves the shift register
   assert_sr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(sr));

   assert_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && load_n) |=> ($stable(in_a) && $stable(in_b)));

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && !xfer_rise) |=> ($stable(out_a) && $stable(out_b)));

   assert_out_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n && xfer_rise) |=> (out_a == $past(in_a) && out_b == $past(in_b)));

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> (out_a == ($past(clr_mid) ? MID : '0) && in_b == ($past(clr_mid) ? MID : '0)));
endmodule

bind dual_dac_loader ddl_checker #(.W(FRAME_W), .V(VAL_W)) u_chk (
   .clk(clk_i), .rst_n(por_n_i), .step(shift_step), .din(sdin_s), .sr(shreg),
   .xfer_rise(xfer_rise), .clr_n(clr_n_s), .clr_mid(clr_mid_s), .load_n(load_n_s),
   .in_a(in_a), .in_b(in_b), .out_a(ch_a_o), .out_b(ch_b_o)
);

// File: tb/dual_dac_loader_tb.sv
module dual_dac_loader_tb;
   logic clk = 1'b0;
   always #2.5ns clk = ~clk;

   logic por_n = 1'b0;
   logic cs = 1'b1, sck = 1'b1, sdi = 1'b0, load_n = 1'b1, xfer = 1'b0;
   logic clr_n = 1'b1, clr_mid = 1'b0;

   logic        sdo [3];
   logic [15:0] oa [3];
   logic [15:0] ob [3];

   dual_dac_loader u_dut (.clk_i(clk), .por_n_i(por_n), .csel_n_i(cs), .sclk_i(sck),
      .sdin_i(sdi), .load_n_i(load_n), .xfer_i(xfer), .clr_n_i(clr_n), .clr_mid_i(clr_mid),
      .sdout_o(sdo[0]), .ch_a_o(oa[0]), .ch_b_o(ob[0]));
   dual_dac_loader u_mid (.clk_i(clk), .por_n_i(por_n), .csel_n_i(cs), .sclk_i(sck),
      .sdin_i(sdo[0]), .load_n_i(load_n), .xfer_i(xfer), .clr_n_i(clr_n), .clr_mid_i(clr_mid),
      .sdout_o(sdo[1]), .ch_a_o(oa[1]), .ch_b_o(ob[1]));
   dual_dac_loader u_last (.clk_i(clk), .por_n_i(por_n), .csel_n_i(cs), .sclk_i(sck),
      .sdin_i(sdo[1]), .load_n_i(load_n), .xfer_i(xfer), .clr_n_i(clr_n), .clr_mid_i(clr_mid),
      .sdout_o(sdo[2]), .ch_a_o(oa[2]), .ch_b_o(ob[2]));

   // bench model
   logic [71:0] chain = '0;
   logic [15:0] m_in  [3][2];
   logic [15:0] m_out [3][2];

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_pins(input logic c, input logic k, input logic d);
      logic old_or;
      old_or = cs | sck;
      cs = c; sck = k; sdi = d;
      if (!old_or && (c | k)) chain = {chain[70:0], d};
      wait_cyc(5);
   endtask

   function automatic logic [23:0] dev_word(input int d);
      return chain[24*d +: 24];
   endfunction

   task automatic send_chain(input logic [23:0] w0, input logic [23:0] w1, input logic [23:0] w2,
                             input bit extra);
      logic [71:0] s;
      s = {w2, w1, w0};
      set_pins(1'b0, 1'b1, sdi);
      for (int i = 71; i >= 0; i--) begin
         set_pins(1'b0, 1'b0, s[i]);
         set_pins(1'b0, 1'b1, s[i]);
      end
      if (extra) begin
         set_pins(1'b0, 1'b0, 1'b1);
         set_pins(1'b1, 1'b0, 1'b1);   // chip-select rise with clock low: extra shift
         set_pins(1'b1, 1'b1, 1'b1);
      end else begin
         set_pins(1'b1, 1'b1, sdi);
      end
   endtask

   task automatic do_load();
      load_n = 1'b0;
      wait_cyc(6);
      load_n = 1'b1;
      for (int d = 0; d < 3; d++) begin
         logic [23:0] w;
         w = dev_word(d);
         if (w[21] || !w[23]) m_in[d][0] = w[15:0];
         if (w[21] ||  w[23]) m_in[d][1] = w[15:0];
      end
      wait_cyc(6);
   endtask

   task automatic do_xfer();
      xfer = 1'b1;
      wait_cyc(6);
      for (int d = 0; d < 3; d++) begin
         m_out[d][0] = m_in[d][0];
         m_out[d][1] = m_in[d][1];
      end
      xfer = 1'b0;
      wait_cyc(6);
   endtask

   task automatic verify(input string tag);
      for (int d = 0; d < 3; d++) begin
         chk($sformatf("%s dev%0d A", tag, d), {16'h0, oa[d]}, {16'h0, m_out[d][0]});
         chk($sformatf("%s dev%0d B", tag, d), {16'h0, ob[d]}, {16'h0, m_out[d][1]});
      end
   endtask

   task automatic verify_sdo(input string tag);
      for (int d = 0; d < 3; d++)
         chk($sformatf("%s dev%0d sdo", tag, d), {31'h0, sdo[d]}, {31'h0, chain[24*d+23]});
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #750us;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         report();
      end
   end

   initial begin
      logic [23:0] w [3];
      int unused;
      unused = $urandom(32'd4242);
      for (int d = 0; d < 3; d++) begin
         m_in[d][0] = '0; m_in[d][1] = '0; m_out[d][0] = '0; m_out[d][1] = '0;
      end
      wait_cyc(4);
      por_n = 1'b1;
      wait_cyc(6);
      verify("R1 power-on");
      verify_sdo("R1 power-on");

      // R2 and R10: write A with a different word per device
      send_chain({8'h00, 16'h1111}, {8'h00, 16'h2222}, {8'h00, 16'h3333}, 0);
      verify_sdo("R1 after frame");
      do_load();
      verify("R6 hold before transfer");
      do_xfer();
      verify("R2 R10 write A");

      // R3: write B, A holds
      send_chain({8'h80, 16'hA5A5}, {8'h80, 16'h5A5A}, {8'h80, 16'hC3C3}, 0);
      do_load();
      do_xfer();
      verify("R3 write B");

      // R6: xfer held high gives no second copy
      send_chain({8'h00, 16'h0F0F}, {8'h00, 16'hF0F0}, {8'h00, 16'h1234}, 0);
      xfer = 1'b1; wait_cyc(6);
      for (int d = 0; d < 3; d++) begin m_out[d][0] = m_in[d][0]; m_out[d][1] = m_in[d][1]; end
      do_load();
      verify("R6 no update while high");
      xfer = 1'b0; wait_cyc(6);
      do_xfer();
      verify("R6 next rising edge");

      // R4: quick load with ignored bits set and select=1
      send_chain({8'hFF, 16'hBEEF}, {8'hE0 | 8'h20, 16'hCAFE}, {8'h7F, 16'h4321}, 0);
      do_load();
      do_xfer();
      verify("R4 quick load");

      // R5: shift without load, transfer shows old values
      send_chain({8'h20, 16'hDEAD}, {8'h20, 16'hDEAD}, {8'h20, 16'hDEAD}, 0);
      do_xfer();
      verify("R5 load high holds");

      // R7: clear to zero, transfer while cleared loses
      clr_mid = 1'b0; clr_n = 1'b0; wait_cyc(6);
      for (int d = 0; d < 3; d++) begin
         m_in[d][0] = 16'h0; m_in[d][1] = 16'h0; m_out[d][0] = 16'h0; m_out[d][1] = 16'h0;
      end
      verify("R7 zero-scale");
      xfer = 1'b1; wait_cyc(6); xfer = 1'b0; wait_cyc(6);
      verify("R7 clear beats transfer");
      clr_mid = 1'b1; wait_cyc(6);
      for (int d = 0; d < 3; d++) begin
         m_in[d][0] = 16'h8000; m_in[d][1] = 16'h8000; m_out[d][0] = 16'h8000; m_out[d][1] = 16'h8000;
      end
      verify("R7 mid-scale");
      clr_n = 1'b1; wait_cyc(6);
      clr_mid = 1'b0; wait_cyc(6);
      do_xfer();
      verify("R7 input regs cleared");
      // R8: the shift register kept the last word through the clear
      verify_sdo("R8 after clear");
      do_load();
      do_xfer();
      verify("R8 word survives clear");

      // R9: extra shift when chip select rises with clock low
      send_chain({8'h00, 16'h2468}, {8'h00, 16'h1357}, {8'h80, 16'h0AAA}, 1);
      verify_sdo("R9 extra shift");
      do_load();
      do_xfer();
      verify("R9 extra shift");

      // random frames
      for (int it = 0; it < 16; it++) begin
         for (int d = 0; d < 3; d++) w[d] = 24'($urandom());
         send_chain(w[0], w[1], w[2], ($urandom() % 4) == 0);
         verify_sdo("R1 R10 random");
         if (($urandom() % 3) != 0) do_load();
         do_xfer();
         verify("R2 R3 R4 R10 random");
      end

      done = 1;
      report();
   end
endmodule